// File: doc/BRIEF.md
# Flyback Controller Fault Supervisor

This block decides when a flyback PWM controller may switch. It takes digital comparator flags about the supply rail, the thermal sensor, the feedback node and the current-sense node. From them it produces three outputs: a PWM enable, an enable for the high-voltage start-up current source, and a flag that shows a latched fault.

Start-up follows a hysteretic lockout. The start-up source charges the supply while the block waits for the turn-on flag, and switching runs until the supply falls through the turn-off level. While switching runs, each fault condition drives its own debounce counter. A counter that expires either parks the block in a restart hold or in a latch:

- A restart hold waits for the turn-off level and then starts again.
- A latch waits for a lower reset level.

The thermal input has a slow tier and a fast tier. The open-loop fault follows a strap input that selects latch or auto-restart.

Top module: `fault_supervisor`

## Requirements
- R1: Lockout and turn-on. While in lockout with `vddAboveOn` high at a clock edge, `pwmEn` is high after that edge. While running with `vddBelowOff` high at a clock edge, `pwmEn` is low and `startEn` is high after that edge.
- R2: `startEn` is high only in lockout. It falls on the same edge on which `pwmEn` rises.
- R3: Over-voltage fault. `vddOver` sampled high on `DLY_OVP` consecutive edges while running turns `pwmEn` off with `faultLatched` low and `startEn` low. The block stays there until `vddBelowOff` is sampled high, then it enters lockout with `startEn` high.
- R4: Slow thermal fault. `tempWarn` high on `DLY_OTP_SLOW` consecutive edges while running turns `pwmEn` off and sets `faultLatched`.
- R5: Fast thermal fault. `tempCrit` high on `DLY_OTP_FAST` consecutive edges while running turns `pwmEn` off and sets `faultLatched`.
- R6: Open-loop fault. `fbOpen` high on `DLY_OLP` consecutive edges while running turns `pwmEn` off. If `restartMode` is 1 the block enters the restart hold of R3. If `restartMode` is 0 it sets `faultLatched`.
- R7: Sense-short fault. `senseLow` high on `DLY_SCP` consecutive edges while running enters the restart hold (no latch).
- R8: A debounce count restarts from zero whenever its flag is sampled low. A flag that is high for one cycle fewer than its delay, dropped and raised again, leaves `pwmEn` high.
- R9: A latched fault ignores `vddBelowOff` and `vddAboveOn`. Only `vddBelowRst` sampled high clears `faultLatched` and enters lockout.
- R10: When `vddBelowOff` is high on the edge where a fault expires, the supply drop wins: the block enters lockout and `faultLatched` stays low.
- R11: After reset, `pwmEn` = 0, `startEn` = 1 and `faultLatched` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vddAboveOn | input | 1 | Supply at or above the turn-on level |
| vddBelowOff | input | 1 | Supply below the turn-off level |
| vddBelowRst | input | 1 | Supply below the latch-release level |
| vddOver | input | 1 | Supply above the over-voltage level |
| tempWarn | input | 1 | Thermal sense below the slow-tier level |
| tempCrit | input | 1 | Thermal sense below the fast-tier level |
| fbOpen | input | 1 | Feedback above the open-loop level |
| senseLow | input | 1 | Current sense stuck below the short level |
| restartMode | input | 1 | 1: open-loop fault auto-restarts, 0: open-loop fault latches |
| pwmEn | output | 1 | Switching permitted |
| startEn | output | 1 | Start-up current source on |
| faultLatched | output | 1 | Latched fault present |

## Verification
A wrong state register shows up as the wrong combination of the three outputs in the cycle after the faulty edge. The bench sees it at once, because its reference model predicts all three on every clock. A counter that is off by one moves the falling edge of `pwmEn` by one cycle. A counter that is not cleared on a dropped flag ends switching early in the glitch sequences. A wrong latch or restart choice shows as `faultLatched` set or clear, and as a wrong reaction to the turn-off flag some cycles later.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

  localparam int unsigned NUM_FAULT = 5;

  // Bit positions in the condition and hit vectors
  localparam int unsigned IDX_SCP      = 0;
  localparam int unsigned IDX_OLP      = 1;
  localparam int unsigned IDX_OTP_FAST = 2;
  localparam int unsigned IDX_OTP_SLOW = 3;
  localparam int unsigned IDX_OVP      = 4;

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_LATCH = 2'd3
  } supState_t;

  // Member order matches the bit positions above (first member is the MSB)
  typedef struct packed {
    logic ovp;
    logic otpSlow;
    logic otpFast;
    logic olp;
    logic scp;
  } faultHit_t;

  typedef struct packed {
    logic armTimers;
  } timerCtl_t;

endpackage

// File: rtl/fsv_debounce.sv
module fsv_debounce #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  assign hit = arm && cond && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!arm || !cond) begin
      cnt <= '0;
    end else if (!hit) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsv_timer_bank.sv
module fsv_timer_bank
  import fsv_pkg::*;
#(
  parameter int unsigned DLY_OVP      = 125,
  parameter int unsigned DLY_OTP_SLOW = 20000,
  parameter int unsigned DLY_OTP_FAST = 130,
  parameter int unsigned DLY_OLP      = 56000,
  parameter int unsigned DLY_SCP      = 150
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  timerCtl_t            ctl,
  input  logic [NUM_FAULT-1:0] condVec,
  output faultHit_t            hits
);
  localparam int unsigned DLY_TAB [NUM_FAULT] =
    '{DLY_SCP, DLY_OLP, DLY_OTP_FAST, DLY_OTP_SLOW, DLY_OVP};

  logic [NUM_FAULT-1:0] hitVec;

  for (genvar g = 0; g < NUM_FAULT; g++) begin : g_tmr
    fsv_debounce #(.DELAY(DLY_TAB[g])) deb_i (
      .clk (clk),
      .rstN(rstN),
      .arm (ctl.armTimers),
      .cond(condVec[g]),
      .hit (hitVec[g])
    );
  end

  assign hits = faultHit_t'(hitVec);
endmodule

// File: rtl/fsv_ctrl.sv
module fsv_ctrl
  import fsv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      vddAboveOn,
  input  logic      vddBelowOff,
  input  logic      vddBelowRst,
  input  logic      restartMode,
  input  faultHit_t hits,
  output timerCtl_t ctl,
  output supState_t state
);
  supState_t nextState;
  logic      latchHit;
  logic      holdHit;

  assign latchHit = hits.otpSlow || hits.otpFast || (hits.olp && !restartMode);
  assign holdHit  = hits.ovp || hits.scp || (hits.olp && restartMode);

  assign ctl.armTimers = (state == ST_RUN);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_LOCK:  if (vddAboveOn) nextState = ST_RUN;
      ST_RUN: begin
        if (vddBelowOff)   nextState = ST_LOCK;
        else if (latchHit) nextState = ST_LATCH;
        else if (holdHit)  nextState = ST_HOLD;
      end
      ST_HOLD:  if (vddBelowOff) nextState = ST_LOCK;
      ST_LATCH: if (vddBelowRst) nextState = ST_LOCK;
      default:  nextState = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCK;
    else       state <= nextState;
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsv_pkg::*;
#(
  parameter int unsigned DLY_OVP      = 125,
  parameter int unsigned DLY_OTP_SLOW = 20000,
  parameter int unsigned DLY_OTP_FAST = 130,
  parameter int unsigned DLY_OLP      = 56000,
  parameter int unsigned DLY_SCP      = 150
) (
  input  logic clk,
  input  logic rstN,
  input  logic vddAboveOn,
  input  logic vddBelowOff,
  input  logic vddBelowRst,
  input  logic vddOver,
  input  logic tempWarn,
  input  logic tempCrit,
  input  logic fbOpen,
  input  logic senseLow,
  input  logic restartMode,
  output logic pwmEn,
  output logic startEn,
  output logic faultLatched
);
  timerCtl_t            ctl;
  faultHit_t            hits;
  supState_t            state;
  logic [NUM_FAULT-1:0] condVec;

  always_comb begin
    condVec               = '0;
    condVec[IDX_OVP]      = vddOver;
    condVec[IDX_OTP_SLOW] = tempWarn;
    condVec[IDX_OTP_FAST] = tempCrit;
    condVec[IDX_OLP]      = fbOpen;
    condVec[IDX_SCP]      = senseLow;
  end

  fsv_timer_bank #(
    .DLY_OVP     (DLY_OVP),
    .DLY_OTP_SLOW(DLY_OTP_SLOW),
    .DLY_OTP_FAST(DLY_OTP_FAST),
    .DLY_OLP     (DLY_OLP),
    .DLY_SCP     (DLY_SCP)
  ) bank_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .condVec(condVec),
    .hits   (hits)
  );

  fsv_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .vddAboveOn (vddAboveOn),
    .vddBelowOff(vddBelowOff),
    .vddBelowRst(vddBelowRst),
    .restartMode(restartMode),
    .hits       (hits),
    .ctl        (ctl),
    .state      (state)
  );

  assign pwmEn        = (state == ST_RUN);
  assign startEn      = (state == ST_LOCK);
  assign faultLatched = (state == ST_LATCH);
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic vddAboveOn,
  input logic vddBelowOff,
  input logic vddBelowRst,
  input logic vddOver,
  input logic tempWarn,
  input logic tempCrit,
  input logic fbOpen,
  input logic senseLow,
  input logic restartMode,
  input logic pwmEn,
  input logic startEn,
  input logic faultLatched
);
  logic holding;
  assign holding = !pwmEn && !startEn && !faultLatched;

  p_turn_on_r1: assert property (@(posedge clk) disable iff (!rstN)
    startEn && vddAboveOn |=> pwmEn);

  p_uvlo_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn && vddBelowOff |=> !pwmEn && startEn);

  p_start_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startEn) |-> pwmEn);

  p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    holding && !vddBelowOff |=> holding);

  p_hold_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    holding && vddBelowOff |=> startEn);

  p_latch_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched && !vddBelowRst |=> faultLatched && !pwmEn);

  p_latch_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched && vddBelowRst |=> startEn && !faultLatched);

  p_drop_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn && vddBelowOff |=> !faultLatched);
endmodule

bind fault_supervisor fault_supervisor_chk chk_i (.*);

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DOVP  = 6;
  localparam int DOTP1 = 40;
  localparam int DOTP2 = 4;
  localparam int DOLP  = 25;
  localparam int DSCP  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vddAboveOn = 1'b0, vddBelowOff = 1'b1, vddBelowRst = 1'b1;
  logic vddOver = 1'b0, tempWarn = 1'b0, tempCrit = 1'b0;
  logic fbOpen = 1'b0, senseLow = 1'b0, restartMode = 1'b1;
  logic pwmEn, startEn, faultLatched;

  int checks = 0;
  int errors = 0;
  string curReq = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor #(
    .DLY_OVP(DOVP), .DLY_OTP_SLOW(DOTP1), .DLY_OTP_FAST(DOTP2),
    .DLY_OLP(DOLP), .DLY_SCP(DSCP)
  ) dut_i (.*);

  // Reference model: 0 lockout, 1 run, 2 hold, 3 latch
  int mState = 0;
  int cnt [5] = '{0, 0, 0, 0, 0};
  int dly [5] = '{DOVP, DOTP1, DOTP2, DOLP, DSCP};
  logic cond [5];
  logic mLatchFire, mHoldFire;

  always @(posedge clk) begin
    cond = '{vddOver, tempWarn, tempCrit, fbOpen, senseLow};
    if (!rstN) begin
      mState = 0;
      foreach (cnt[i]) cnt[i] = 0;
    end else begin
      mLatchFire = 1'b0;
      mHoldFire  = 1'b0;
      foreach (cnt[i]) begin
        if (mState == 1 && cond[i]) begin
          cnt[i] = cnt[i] + 1;
          if (cnt[i] >= dly[i]) begin
            if (i == 1 || i == 2 || (i == 3 && !restartMode)) mLatchFire = 1'b1;
            else mHoldFire = 1'b1;
          end
        end else begin
          cnt[i] = 0;
        end
      end
      case (mState)
        0: if (vddAboveOn) mState = 1;
        1: begin
          if (vddBelowOff)     mState = 0;
          else if (mLatchFire) mState = 3;
          else if (mHoldFire)  mState = 2;
          if (mState != 1) foreach (cnt[i]) cnt[i] = 0;
        end
        2: if (vddBelowOff) mState = 0;
        default: if (vddBelowRst) mState = 0;
      endcase
    end
  end

  function automatic logic [2:0] modelOut();
    return {mState == 1, mState == 0, mState == 3};
  endfunction

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    checks++;
    if ({pwmEn, startEn, faultLatched} !== modelOut()) begin
      errors++;
      $display("FAIL %s cycle compare: actual pwm/start/latch=%b expected=%b",
               curReq, {pwmEn, startEn, faultLatched}, modelOut());
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic [2:0] exp);
    checks++;
    if ({pwmEn, startEn, faultLatched} !== exp) begin
      errors++;
      $display("FAIL %s directed: actual pwm/start/latch=%b expected=%b",
               req, {pwmEn, startEn, faultLatched}, exp);
    end
  endtask

  task automatic powerUp();
    vddBelowRst = 1'b0; vddBelowOff = 1'b0;
    step(2);
    vddAboveOn = 1'b1; step(1);
    vddAboveOn = 1'b0; step(1);
  endtask

  task automatic dropToLock();
    vddBelowOff = 1'b1; step(2);
    vddBelowOff = 1'b0; step(1);
  endtask

  task automatic resetLatch();
    vddBelowOff = 1'b1; vddBelowRst = 1'b1; step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    expect3("R11", 3'b010);

    // R1 / R2: turn-on and supply drop
    curReq = "R1";
    vddBelowRst = 1'b0; vddBelowOff = 1'b0; step(2);
    expect3("R2", 3'b010);
    vddAboveOn = 1'b1; step(1);
    expect3("R2", 3'b100);
    vddAboveOn = 1'b0; step(3);
    dropToLock();
    expect3("R1", 3'b010);
    powerUp();
    expect3("R1", 3'b100);

    // R8: glitches one cycle short of the delay
    curReq = "R8";
    for (int k = 0; k < 3; k++) begin
      senseLow = 1'b1; step(DSCP - 1);
      senseLow = 1'b0; step(1);
    end
    for (int k = 0; k < 2; k++) begin
      tempWarn = 1'b1; step(DOTP1 - 1);
      tempWarn = 1'b0; step(1);
    end
    expect3("R8", 3'b100);

    // R7: sense short -> restart hold
    curReq = "R7";
    senseLow = 1'b1; step(DSCP + 2);
    expect3("R7", 3'b000);
    senseLow = 1'b0; step(3);
    expect3("R7", 3'b000);
    dropToLock();
    expect3("R7", 3'b010);
    powerUp();

    // R3: over-voltage -> hold, no latch
    curReq = "R3";
    vddOver = 1'b1; step(DOVP - 1);
    expect3("R3", 3'b100);
    step(1);
    expect3("R3", 3'b000);
    vddOver = 1'b0; step(4);
    expect3("R3", 3'b000);
    dropToLock();
    expect3("R3", 3'b010);
    powerUp();

    // R6: open loop, restart variant
    curReq = "R6";
    restartMode = 1'b1;
    fbOpen = 1'b1; step(DOLP + 1);
    expect3("R6", 3'b000);
    fbOpen = 1'b0;
    dropToLock();
    powerUp();

    // R4: slow thermal tier -> latch; R9: turn-off level ignored
    curReq = "R4";
    tempWarn = 1'b1; step(DOTP1);
    expect3("R4", 3'b001);
    tempWarn = 1'b0;
    curReq = "R9";
    vddBelowOff = 1'b1; step(3);
    vddAboveOn = 1'b1; step(2);
    expect3("R9", 3'b001);
    vddAboveOn = 1'b0; vddBelowOff = 1'b0; step(2);
    resetLatch();
    expect3("R9", 3'b010);
    powerUp();

    // R5: fast thermal tier -> latch
    curReq = "R5";
    tempCrit = 1'b1; step(DOTP2);
    expect3("R5", 3'b001);
    tempCrit = 1'b0;
    resetLatch();
    powerUp();

    // R6: open loop, latch variant
    curReq = "R6";
    restartMode = 1'b0;
    fbOpen = 1'b1; step(DOLP + 1);
    expect3("R6", 3'b001);
    fbOpen = 1'b0;
    resetLatch();
    powerUp();

    // R10: supply drop on the expiry edge wins over a latching fault
    curReq = "R10";
    tempCrit = 1'b1; step(DOTP2 - 1);
    vddBelowOff = 1'b1; step(1);
    expect3("R10", 3'b010);
    tempCrit = 1'b0; vddBelowOff = 1'b0; step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule